// File: doc/BRIEF.md
# Interrupt Enable and Return-Address Controller

This block holds the global interrupt-enable state of a small processor core together with a return-address stack that a stack pointer addresses. It samples the core's decode strobes for enable, disable and return-from-interrupt only at instruction boundaries, which `instr_done` marks. It also watches a single interrupt request line. When the enable is set at a boundary and the request is high, the block acknowledges the interrupt, saves the current program counter and masks further interrupts. A return-from-interrupt pops the saved address, and the block hands it back to the fetch logic with a one-cycle load strobe.

The enable is kept by a three-state machine: `EN_OFF`, `EN_ARMED` and `EN_ON`. An enable instruction completing in `EN_OFF` moves the machine to `EN_ARMED` (transition *arm*). The next completed instruction moves it to `EN_ON` (transition *settle*). A disable instruction takes any state to `EN_OFF` (transition *drop*). An acknowledge takes `EN_ON` to `EN_OFF` (transition *take*). A chip-enable reset or a clock-stop strobe forces `EN_OFF` from any state (transition *clear*). Power-on reset, which is asynchronous and active low, puts the machine in `EN_OFF`. The stack pushes with a pre-decrement and pops with a post-increment. The pointer wraps modulo the depth, so nesting deeper than the stack silently overwrites the oldest saved address.

Top module: `intr_ret_ctl`

## Requirements
- R1: While `rst_n` is low and after it rises, `ie_o`=0, `ack_o`=0, `pc_load_o`=0, `sp_o`=0 and `pc_ret_o`=0.
- R2: An enable strobe (`op_ei`=1 with `instr_done`=1) taken while disabled leaves `ie_o` at 0 after that boundary. `ie_o` becomes 1 in the cycle after the next boundary that carries no disable strobe.
- R3: A disable strobe at a boundary drives `ie_o` to 0 in the next cycle, cancels a pending enable, and blocks an acknowledge at that boundary.
- R4: An enable strobe while enabled, or a disable strobe while disabled, leaves `ie_o` unchanged.
- R5: `ack_o` is a one-cycle pulse in the cycle after an edge where `instr_done`=1, `irq_req`=1 and `ie_o`=1, with `op_di`, `op_reti`, `ce_rst` and `stop_exec` all 0. In every other case `ack_o` stays 0, including when interrupts are masked.
- R6: An acknowledge drives `ie_o` to 0 in the same cycle `ack_o` is high.
- R7: On an acknowledge, `sp_o` decreases by one modulo 8, and the `pc_in` value from the boundary is stored at the new pointer.
- R8: A return strobe (`op_reti`=1 with `instr_done`=1) gives, in the next cycle, `pc_load_o`=1 and `pc_ret_o` equal to the entry the old pointer addressed, with `sp_o` increased by one modulo 8.
- R9: The stack holds 8 entries of 12 bits. A ninth nested push overwrites the first saved address, and pops return addresses in last-in first-out order.
- R10: `ce_rst` or `stop_exec` high at an edge gives `ie_o`=0 in the next cycle and cancels a pending enable. Neither changes `sp_o`.
- R11: Decode strobes and `irq_req` have no effect while `instr_done` is 0.
- R12: When a return strobe and a pending request meet at one boundary, the return completes and the acknowledge waits for the following boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| ce_rst | input | 1 | Chip-enable reset, synchronous, clears the enable |
| stop_exec | input | 1 | Clock-stop instruction strobe, clears the enable |
| instr_done | input | 1 | Instruction boundary: the current instruction completes this cycle |
| op_ei | input | 1 | Completing instruction is enable-interrupts |
| op_di | input | 1 | Completing instruction is disable-interrupts |
| op_reti | input | 1 | Completing instruction is return-from-interrupt |
| irq_req | input | 1 | Interrupt request |
| pc_in | input | 12 | Program counter to save on acknowledge |
| ie_o | output | 1 | Global interrupt enable |
| ack_o | output | 1 | Acknowledge pulse |
| pc_ret_o | output | 12 | Restored return address |
| pc_load_o | output | 1 | Load strobe for `pc_ret_o` |
| sp_o | output | 3 | Stack pointer |

## Verification
Every output is registered or decoded from registered state. An acknowledge, a pop, a pointer step or a disable therefore shows up exactly one cycle after the rising edge that sampled its boundary. An enable shows up one cycle after the second boundary, counted from the enable instruction. The bench drives each boundary on a falling edge and holds it through one rising edge. It samples at the next falling edge, which lands on the cycle in which the result is due. For the delayed enable it samples after both the first and the second boundary, so an early or late change is caught.

// File: rtl/intr_ret_pkg.sv
`timescale 1ns/1ps
package intr_ret_pkg;
    typedef enum logic [1:0] {
        EN_OFF   = 2'd0,
        EN_ARMED = 2'd1,
        EN_ON    = 2'd2
    } ie_state_t;
endpackage

// File: rtl/intr_en_fsm.sv
`timescale 1ns/1ps
module intr_en_fsm
    import intr_ret_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bnd,
    input  logic ei,
    input  logic di,
    input  logic reti,
    input  logic irq,
    output logic take,
    output logic ie,
    output logic ack
);
    ie_state_t st_q, st_d;
    logic      take_d;

    // Next state and the acknowledge decision
    always_comb begin
        st_d   = st_q;
        take_d = 1'b0;
        if (clr) begin
            st_d = EN_OFF;                      // clear
        end else if (bnd) begin
            unique case (st_q)
                EN_OFF: begin
                    if (di)      st_d = EN_OFF;
                    else if (ei) st_d = EN_ARMED;   // arm
                end
                EN_ARMED: begin
                    if (di) st_d = EN_OFF;          // drop
                    else    st_d = EN_ON;           // settle
                end
                EN_ON: begin
                    if (di) begin
                        st_d = EN_OFF;              // drop
                    end else if (irq && !reti) begin
                        take_d = 1'b1;
                        st_d   = EN_OFF;            // take
                    end
                end
                default: st_d = EN_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= EN_OFF;
        else        st_q <= st_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ack <= 1'b0;
        else        ack <= take_d;
    end

    assign take = take_d;
    assign ie   = (st_q == EN_ON);
endmodule

// File: rtl/ret_stack.sv
`timescale 1ns/1ps
module ret_stack #(
    parameter int AW    = 12,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_data,
    output logic [AW-1:0] pop_data,
    output logic          pop_vld,
    output logic [PW-1:0] sp
);
    localparam logic [PW-1:0] ONE = {{(PW-1){1'b0}}, 1'b1};

    logic [AW-1:0] mem [DEPTH];
    logic [PW-1:0] sp_q;
    logic [PW-1:0] sp_dec;

    assign sp_dec = sp_q - ONE;

    // Pre-decrement on push, post-increment on pop; pointer wraps
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q     <= '0;
            pop_data <= '0;
            pop_vld  <= 1'b0;
        end else begin
            pop_vld <= pop;
            if (push) begin
                sp_q <= sp_dec;
            end else if (pop) begin
                pop_data <= mem[sp_q];
                sp_q     <= sp_q + ONE;
            end
        end
    end

    // Storage, written without reset
    always_ff @(posedge clk) begin
        if (push) mem[sp_dec] <= push_data;
    end

    assign sp = sp_q;
endmodule

// File: rtl/intr_ret_ctl.sv
`timescale 1ns/1ps
module intr_ret_ctl #(
    parameter int AW    = 12,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_rst,
    input  logic          stop_exec,
    input  logic          instr_done,
    input  logic          op_ei,
    input  logic          op_di,
    input  logic          op_reti,
    input  logic          irq_req,
    input  logic [AW-1:0] pc_in,
    output logic          ie_o,
    output logic          ack_o,
    output logic [AW-1:0] pc_ret_o,
    output logic          pc_load_o,
    output logic [PW-1:0] sp_o
);
    logic clr;
    logic take;
    logic pop;

    assign clr = ce_rst | stop_exec;
    assign pop = instr_done & op_reti;

    intr_en_fsm u_fsm (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .bnd  (instr_done),
        .ei   (op_ei),
        .di   (op_di),
        .reti (op_reti),
        .irq  (irq_req),
        .take (take),
        .ie   (ie_o),
        .ack  (ack_o)
    );

    ret_stack #(.AW(AW), .DEPTH(DEPTH)) u_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (take),
        .pop      (pop),
        .push_data(pc_in),
        .pop_data (pc_ret_o),
        .pop_vld  (pc_load_o),
        .sp       (sp_o)
    );
endmodule

// File: rtl/intr_ret_ctl_chk.sv
`timescale 1ns/1ps
module intr_ret_ctl_chk #(
    parameter int PW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_rst,
    input logic          stop_exec,
    input logic          instr_done,
    input logic          op_di,
    input logic          op_reti,
    input logic          irq_req,
    input logic          ie_o,
    input logic          ack_o,
    input logic          pc_load_o,
    input logic [PW-1:0] sp_o
);
    localparam logic [PW-1:0] ONE = {{(PW-1){1'b0}}, 1'b1};

    a_r5_ack_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(instr_done) && $past(irq_req) && $past(ie_o) && !$past(op_di));

    a_r6_ack_masks: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> !ie_o);

    a_r7_push_predec: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> sp_o == ($past(sp_o) - ONE));

    a_r8_pop_postinc: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |-> sp_o == ($past(sp_o) + ONE));

    a_r2_rise_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ie_o) |-> $past(instr_done) && !$past(op_di));

    a_r3_di_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done && op_di) |=> !ie_o && !ack_o);

    a_r10_clear_sources: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_rst || stop_exec) |=> !ie_o && !ack_o);

    a_r11_idle_holds_sp: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_done |=> $stable(sp_o) && !ack_o && !pc_load_o);

    a_r12_reti_defers_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done && op_reti) |=> !ack_o);

    a_r12_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_o && pc_load_o));
endmodule

bind intr_ret_ctl intr_ret_ctl_chk #(.PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_rst    (ce_rst),
    .stop_exec (stop_exec),
    .instr_done(instr_done),
    .op_di     (op_di),
    .op_reti   (op_reti),
    .irq_req   (irq_req),
    .ie_o      (ie_o),
    .ack_o     (ack_o),
    .pc_load_o (pc_load_o),
    .sp_o      (sp_o)
);

// File: tb/sim_intr_ret_ctl.sv
`timescale 1ns/1ps
module sim_intr_ret_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_rst = 1'b0, stop_exec = 1'b0, instr_done = 1'b0;
    logic        op_ei = 1'b0, op_di = 1'b0, op_reti = 1'b0, irq_req = 1'b0;
    logic [11:0] pc_in = '0;
    logic        ie_o, ack_o, pc_load_o;
    logic [11:0] pc_ret_o;
    logic [2:0]  sp_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    intr_ret_ctl u0 (
        .clk(clk), .rst_n(rst_n), .ce_rst(ce_rst), .stop_exec(stop_exec),
        .instr_done(instr_done), .op_ei(op_ei), .op_di(op_di), .op_reti(op_reti),
        .irq_req(irq_req), .pc_in(pc_in), .ie_o(ie_o), .ack_o(ack_o),
        .pc_ret_o(pc_ret_o), .pc_load_o(pc_load_o), .sp_o(sp_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, pass one rising edge, return at the next falling edge
    task automatic cyc(input logic bnd, input logic ei, input logic di, input logic rt,
                       input logic rq, input logic [11:0] pc);
        instr_done = bnd; op_ei = ei; op_di = di; op_reti = rt; irq_req = rq; pc_in = pc;
        @(posedge clk);
        @(negedge clk);
        instr_done = 0; op_ei = 0; op_di = 0; op_reti = 0; irq_req = 0;
    endtask

    task automatic enable_now();
        cyc(1, 1, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0);
    endtask

    task automatic t_reset();
        rst_n = 0;
        @(negedge clk);
        chk("R1 ie", ie_o, 0); chk("R1 sp", sp_o, 0);
        chk("R1 ack", ack_o, 0); chk("R1 load", pc_load_o, 0); chk("R1 pc", pc_ret_o, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 ie after release", ie_o, 0);
    endtask

    task automatic t_ei_delay();
        cyc(1, 1, 0, 0, 0, 0);
        chk("R2 ie after EI boundary", ie_o, 0);
        cyc(0, 0, 0, 0, 0, 0);
        chk("R2 ie still pending", ie_o, 0);
        cyc(1, 0, 0, 0, 0, 0);
        chk("R2 ie after next boundary", ie_o, 1);
        cyc(1, 1, 0, 0, 0, 0);
        chk("R4 EI while enabled", ie_o, 1);
    endtask

    task automatic t_di();
        cyc(1, 0, 1, 0, 1, 12'h111);
        chk("R3 ie after DI", ie_o, 0);
        chk("R3 no ack at DI", ack_o, 0);
        cyc(1, 0, 1, 0, 0, 0);
        chk("R4 DI while disabled", ie_o, 0);
        cyc(1, 1, 0, 0, 0, 0);
        cyc(1, 0, 1, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0);
        chk("R3 DI cancels pending EI", ie_o, 0);
    endtask

    task automatic t_masked_and_idle();
        cyc(1, 0, 0, 0, 1, 12'h222);
        chk("R5 masked ack", ack_o, 0);
        chk("R5 masked sp", sp_o, 0);
        cyc(0, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0);
        chk("R11 EI without boundary", ie_o, 0);
        enable_now();
        cyc(0, 0, 1, 1, 1, 12'h333);
        chk("R11 idle ack", ack_o, 0);
        chk("R11 idle load", pc_load_o, 0);
        chk("R11 idle ie", ie_o, 1);
        chk("R11 idle sp", sp_o, 0);
    endtask

    task automatic t_push_pop();
        cyc(1, 0, 0, 0, 1, 12'h5A5);
        chk("R5 ack", ack_o, 1);
        chk("R6 ie on ack", ie_o, 0);
        chk("R7 sp after push", sp_o, 7);
        cyc(0, 0, 0, 0, 0, 0);
        chk("R5 ack one cycle", ack_o, 0);
        cyc(1, 0, 0, 1, 0, 0);
        chk("R8 load", pc_load_o, 1);
        chk("R8 pc", pc_ret_o, 12'h5A5);
        chk("R8 sp", sp_o, 0);
    endtask

    task automatic t_wrap();
        for (int i = 1; i <= 9; i++) begin
            enable_now();
            cyc(1, 0, 0, 0, 1, 12'h100 + 12'(i));
        end
        chk("R9 sp after 9 pushes", sp_o, 7);
        cyc(1, 0, 0, 1, 0, 0);
        chk("R9 first pop", pc_ret_o, 12'h109);
        for (int i = 2; i <= 8; i++) begin
            cyc(1, 0, 0, 1, 0, 0);
            chk("R9 lifo pop", pc_ret_o, 12'h100 + 12'(10 - i));
        end
        chk("R9 sp after 8 pops", sp_o, 7);
    endtask

    task automatic t_clear();
        enable_now();
        ce_rst = 1; cyc(0, 0, 0, 0, 0, 0); ce_rst = 0;
        chk("R10 ce_rst clears", ie_o, 0);
        chk("R10 ce_rst keeps sp", sp_o, 7);
        cyc(1, 1, 0, 0, 0, 0);
        stop_exec = 1; cyc(0, 0, 0, 0, 0, 0); stop_exec = 0;
        cyc(1, 0, 0, 0, 0, 0);
        chk("R10 stop cancels pending", ie_o, 0);
        enable_now();
        stop_exec = 1; cyc(1, 0, 0, 0, 1, 12'h444); stop_exec = 0;
        chk("R10 stop blocks ack", ack_o, 0);
        chk("R10 stop clears", ie_o, 0);
    endtask

    task automatic t_reti_defer();
        enable_now();
        cyc(1, 0, 0, 1, 1, 12'h777);
        chk("R12 reti load", pc_load_o, 1);
        chk("R12 no ack at reti", ack_o, 0);
        chk("R12 sp after pop", sp_o, 0);
        cyc(1, 0, 0, 0, 1, 12'h778);
        chk("R12 ack next boundary", ack_o, 1);
        chk("R12 sp after push", sp_o, 7);
        rst_n = 0; #1;
        chk("R1 async reset sp", sp_o, 0);
        chk("R1 async reset ie", ie_o, 0);
        @(negedge clk); rst_n = 1; @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_ei_delay();
        t_di();
        t_masked_and_idle();
        t_push_pop();
        t_wrap();
        t_clear();
        t_reti_defer();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule